// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked request port and a byte-wide asynchronous static RAM with a 15-bit address and a shared 8-bit data bus. It turns each single-beat read or write request into a strobe sequence with correct timing. The strobes are chip select, write enable and output enable, all active low. The block drives the address, the strobes, the outgoing data and a data-drive enable that a pad-level tristate outside the block uses. It samples the returning byte at the end of the read window. Every timing limit is given in nanoseconds together with the clock period. Each limit is turned into a whole number of cycles, rounded up, with at least one cycle per phase.

Writes can be timed by write enable or by chip select, chosen by a parameter. In the write-enable style, output enable may be held low through the write. The block then holds back its data drive until the memory's output turn-off time has passed, and it stretches the write pulse to make room for the data setup that follows. After every access a turnaround gap lets the memory release the bus. A sleep input parks the memory in standby with chip select high, which makes it safe to lower the supply for data retention. On wake, chip select is held high for one read-cycle time before the next request is accepted.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset: ready_o=1, sram_cs_no=1, sram_we_no=1, sram_oe_no=1, sram_dq_oe_o=0, standby_o=0, rvalid_o=0.
- R2: A request (req_i=1 with we_i=1 for write, we_i=0 for read) is taken at a rising edge only while ready_o=1. ready_o is low from the next cycle on. It returns RD_C+TA_C cycles after a read is taken and AS_C+PUL_C+1+TA_C cycles after a write is taken.
- R3: A read holds sram_cs_no=0, sram_oe_no=0, sram_we_no=1 and the address for RD_C cycles. The data bus is sampled at the last edge of that window. rvalid_o is a one-cycle pulse in the following cycle, and rdata_o then equals the byte last written to that address.
- R4: A write (write-enable style, output enable held low) first spends AS_C cycles with chip select low and write enable high. It then holds write enable low for PUL_C = max(WP_C, GAP_C+DW_C) cycles, where GAP_C = WHZ_C.
- R5: During the first GAP_C cycles of the write pulse the data bus is not driven. After that it is driven with the write byte until the pulse ends, and it stays driven with the same byte and address for one cycle after both strobes rise together.
- R6: The block never drives the data bus while the memory is in read mode (chip select low, write enable high, output enable low), nor in the TA_C cycles that follow read mode.
- R7: Whenever ready_o=1 all three strobes are high and the data bus is not driven.
- R8: sleep_i=1 while idle with no request, or at the end of an access, puts the block in standby: sram_cs_no=1, standby_o=1, ready_o=0. Requests made during standby have no effect on the memory.
- R9: After sleep_i falls, standby_o falls and chip select is held high with ready_o=0 for REC_C cycles. ready_o then returns, and the memory contents are kept.
- R10: Each cycle count is the ceiling of its nanosecond limit divided by CLK_NS, with a minimum of 1. RD_C and REC_C come from the read cycle time, WP_C from the write pulse, DW_C from the data setup, WHZ_C from the write-enable turn-off, TA_C from the output turn-off and AS_C from the address setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write byte |
| sleep_i | input | 1 | Request standby / data retention |
| ready_o | output | 1 | Block idle, request may be taken |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | DATA_W | Registered read byte |
| standby_o | output | 1 | Memory parked in standby, supply may drop |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_cs_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_dq_o | output | DATA_W | Outgoing data byte |
| sram_dq_oe_o | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | DATA_W | Incoming data byte |

## Verification
A cycle-level memory model in the bench drives the bus during read mode, during the write-enable turn-off window and for the turnaround after a read. It flags contention, a pulse that is too short, setup that is too short, missing hold and address movement. A design that drove data on the first pulse cycle, or dropped the turnaround gap, would trip the contention count. A design that did not stretch the pulse would be caught by the setup count and by the per-cycle pulse-shape check. Reads that sample one edge early or late return the bench's filler byte instead of the stored byte. A sleep that lets a pending request through, or a wake that skips the recovery hold, shows up as wrong ready timing or as a byte overwritten during standby.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WSET, ST_WPUL, ST_WEND, ST_TURN, ST_SLEEP, ST_WAKE
  } state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] next_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (load_i)            next_o = load_val_i;
    else if (cnt_q == '0)  next_o = cnt_q;
    else                   next_o = cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= next_o;
  end
endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      dq_o     <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (accept_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW        = 2,
  parameter int unsigned AS_C      = 1,
  parameter int unsigned RD_C      = 2,
  parameter int unsigned PUL_C     = 3,
  parameter int unsigned GAP_C     = 1,
  parameter int unsigned TA_C      = 1,
  parameter int unsigned REC_C     = 2,
  parameter bit          WR_BY_WE  = 1'b1,
  parameter bit          OE_LOW_WR = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          sleep_i,
  input  logic          done_i,
  input  logic [CW-1:0] cnt_next_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          cap_o,
  output logic          ready_o,
  output logic          standby_o,
  output logic          cs_no,
  output logic          we_no,
  output logic          oe_no,
  output logic          dq_oe_o
);
  localparam int unsigned DRV_LAST = PUL_C - 1 - GAP_C;

  state_e state_q, state_d;
  logic   cs_d, we_d, oe_d, drv_d;
  logic   set_cs, set_we, set_oe, set_drv, pul_oe, pul_drv;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_i) state_d = we_i ? ST_WSET : ST_RD;
                else if (sleep_i) state_d = ST_SLEEP;
      ST_RD:    if (done_i) state_d = ST_TURN;
      ST_WSET:  if (done_i) state_d = ST_WPUL;
      ST_WPUL:  if (done_i) state_d = ST_WEND;
      ST_WEND:  state_d = ST_TURN;
      ST_TURN:  if (done_i) state_d = sleep_i ? ST_SLEEP : ST_IDLE;
      ST_SLEEP: if (!sleep_i) state_d = ST_WAKE;
      ST_WAKE:  if (done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign load_o   = (state_d != state_q);
  assign accept_o = (state_q == ST_IDLE) && req_i;
  assign cap_o    = (state_q == ST_RD) && done_i;

  always_comb begin
    case (state_d)
      ST_RD:   load_val_o = CW'(RD_C - 1);
      ST_WSET: load_val_o = CW'(AS_C - 1);
      ST_WPUL: load_val_o = CW'(PUL_C - 1);
      ST_TURN: load_val_o = CW'(TA_C - 1);
      ST_WAKE: load_val_o = CW'(REC_C - 1);
      default: load_val_o = '0;
    endcase
  end

  // write style picks which strobe frames the overlap
  if (WR_BY_WE) begin : g_we_ctrl
    assign set_cs  = 1'b0;
    assign set_we  = 1'b1;
    assign set_oe  = !OE_LOW_WR;
    assign set_drv = 1'b0;
    assign pul_oe  = !OE_LOW_WR;
    assign pul_drv = (cnt_next_i <= CW'(DRV_LAST));
  end else begin : g_cs_ctrl
    assign set_cs  = 1'b1;
    assign set_we  = 1'b0;
    assign set_oe  = 1'b1;
    assign set_drv = 1'b1;
    assign pul_oe  = 1'b1;
    assign pul_drv = 1'b1;
  end

  always_comb begin
    cs_d = 1'b1; we_d = 1'b1; oe_d = 1'b1; drv_d = 1'b0;
    case (state_d)
      ST_RD:   begin cs_d = 1'b0; oe_d = 1'b0; end
      ST_WSET: begin cs_d = set_cs; we_d = set_we; oe_d = set_oe; drv_d = set_drv; end
      ST_WPUL: begin cs_d = 1'b0; we_d = 1'b0; oe_d = pul_oe; drv_d = pul_drv; end
      ST_WEND: drv_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cs_no     <= 1'b1;
      we_no     <= 1'b1;
      oe_no     <= 1'b1;
      dq_oe_o   <= 1'b0;
      ready_o   <= 1'b1;
      standby_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      cs_no     <= cs_d;
      we_no     <= we_d;
      oe_no     <= oe_d;
      dq_oe_o   <= drv_d;
      ready_o   <= (state_d == ST_IDLE);
      standby_o <= (state_d == ST_SLEEP);
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_RC_NS   = 20,
  parameter int unsigned T_WP_NS   = 15,
  parameter int unsigned T_DW_NS   = 11,
  parameter int unsigned T_WHZ_NS  = 10,
  parameter int unsigned T_OFF_NS  = 10,
  parameter int unsigned T_AS_NS   = 0,
  parameter bit          WR_BY_WE  = 1'b1,
  parameter bit          OE_LOW_WR = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sleep_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              standby_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned RD_C  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned REC_C = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned WP_C  = ns2cyc(T_WP_NS, CLK_NS);
  localparam int unsigned DW_C  = ns2cyc(T_DW_NS, CLK_NS);
  localparam int unsigned WHZ_C = ns2cyc(T_WHZ_NS, CLK_NS);
  localparam int unsigned TA_C  = ns2cyc(T_OFF_NS, CLK_NS);
  localparam int unsigned AS_C  = ns2cyc(T_AS_NS, CLK_NS);
  localparam int unsigned GAP_C = (WR_BY_WE && OE_LOW_WR) ? WHZ_C : 0;
  localparam int unsigned PUL_C = WR_BY_WE ? max2(WP_C, GAP_C + DW_C) : max2(WP_C, DW_C);
  localparam int unsigned MAXC  = max2(max2(max2(RD_C, AS_C), max2(PUL_C, TA_C)), REC_C);
  localparam int unsigned CW    = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic          load, done, accept, cap;
  logic [CW-1:0] load_val, cnt_next;

  sram_ctrl_timer #(.CW(CW)) timer_i (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(load_val), .next_o(cnt_next), .done_o(done)
  );

  sram_ctrl_seq #(
    .CW(CW), .AS_C(AS_C), .RD_C(RD_C), .PUL_C(PUL_C), .GAP_C(GAP_C),
    .TA_C(TA_C), .REC_C(REC_C), .WR_BY_WE(WR_BY_WE), .OE_LOW_WR(OE_LOW_WR)
  ) seq_i (
    .clk_i, .rst_ni, .req_i, .we_i, .sleep_i,
    .done_i(done), .cnt_next_i(cnt_next),
    .load_o(load), .load_val_o(load_val), .accept_o(accept), .cap_o(cap),
    .ready_o, .standby_o,
    .cs_no(sram_cs_no), .we_no(sram_we_no), .oe_no(sram_oe_no), .dq_oe_o(sram_dq_oe_o)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk_i, .rst_ni,
    .accept_i(accept), .addr_i, .wdata_i, .cap_i(cap), .dq_i(sram_dq_i),
    .addr_o(sram_addr_o), .dq_o(sram_dq_o), .rvalid_o, .rdata_o
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned GAP_C = 1,
  parameter int unsigned PUL_C = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sram_cs_no,
  input logic sram_we_no,
  input logic sram_oe_no,
  input logic sram_dq_oe_o,
  input logic ready_o,
  input logic rvalid_o,
  input logic standby_o
);
  logic       ovl, rd_mode;
  logic [7:0] ovl_q;

  assign ovl     = !sram_cs_no && !sram_we_no;
  assign rd_mode = !sram_cs_no && sram_we_no && !sram_oe_no;

  // prior overlap cycles, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovl_q <= '0;
    else if (!ovl)   ovl_q <= '0;
    else if (ovl_q != 8'hFF) ovl_q <= ovl_q + 8'd1;
  end

  assert_rd_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mode |-> !sram_dq_oe_o);

  assert_turnaround_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mode |=> !sram_dq_oe_o);

  assert_drive_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && ovl && !sram_oe_no) |-> (ovl_q >= 8'(GAP_C)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);

  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovl_q != 8'd0) && !ovl) |-> (ovl_q >= 8'(PUL_C)));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_cs_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));

  assert_rvalid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_standby_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (sram_cs_no && !ready_o));
endmodule

bind sram_ctrl sram_ctrl_chk #(.GAP_C(GAP_C), .PUL_C(PUL_C)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .sram_cs_no(sram_cs_no), .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no),
  .sram_dq_oe_o(sram_dq_oe_o), .ready_o(ready_o), .rvalid_o(rvalid_o),
  .standby_o(standby_o)
);

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  function automatic int cyc(int ns);
    int c;
    c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction

  // R10: cycle counts from ns limits at 10 ns clock
  localparam int RD  = cyc(20);
  localparam int REC = cyc(20);
  localparam int WP  = cyc(15);
  localparam int DW  = cyc(11);
  localparam int WHZ = cyc(10);
  localparam int TA  = cyc(10);
  localparam int AS  = cyc(0);
  localparam int GAP = WHZ;
  localparam int PUL = (WP > GAP + DW) ? WP : GAP + DW;
  localparam int RD_LAT = RD + TA;
  localparam int WR_LAT = AS + PUL + 1 + TA;

  logic        clk, rst_n;
  logic        req, we, sleep;
  logic [14:0] addr;
  logic [7:0]  wdata;
  logic        ready, rvalid, standby;
  logic [7:0]  rdata;
  logic [14:0] s_addr;
  logic        s_cs_n, s_we_n, s_oe_n, s_dq_oe;
  logic [7:0]  s_dq_o, s_dq_i;

  sram_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .sleep_i(sleep), .ready_o(ready), .rvalid_o(rvalid),
    .rdata_o(rdata), .standby_o(standby), .sram_addr_o(s_addr),
    .sram_cs_no(s_cs_n), .sram_we_no(s_we_n), .sram_oe_no(s_oe_n),
    .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe), .sram_dq_i(s_dq_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int viol_bus = 0, viol_wr = 0;
  logic [7:0] sb [int];

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle-level memory model, evaluated between edges
  logic [7:0]  mem [int];
  int          ovl_n, set_n, weq_n, tail;
  logic        prev_ovl;
  logic [14:0] prev_addr;
  logic [7:0]  wlatch;

  always @(negedge clk) begin
    logic rd_mode, ovl, whz, drv_now;
    if (!rst_n) begin
      ovl_n = 0; set_n = 0; weq_n = 0; tail = 0;
      prev_ovl = 1'b0; prev_addr = '0; wlatch = '0; s_dq_i = 8'h5A;
    end else begin
      rd_mode = !s_cs_n && s_we_n && !s_oe_n;
      ovl     = !s_cs_n && !s_we_n;
      weq_n   = ovl ? weq_n + 1 : 0;
      whz     = ovl && !s_oe_n && (weq_n <= WHZ);
      drv_now = rd_mode || whz;
      if (s_dq_oe && (drv_now || tail > 0)) begin
        viol_bus++;
        $display("model: bus contention at %0t", $time);
      end
      tail = rd_mode ? TA : ((tail > 0) ? tail - 1 : 0);
      if (ovl) begin
        ovl_n++;
        if (s_dq_oe) begin set_n++; wlatch = s_dq_o; end
        else set_n = 0;
        if (s_addr != prev_addr) begin
          viol_wr++;
          $display("model: address moved in write at %0t", $time);
        end
      end else if (prev_ovl) begin
        if (set_n < DW || ovl_n < WP || !s_dq_oe || s_dq_o != wlatch || s_addr != prev_addr) begin
          viol_wr++;
          $display("model: write timing set=%0d pulse=%0d at %0t", set_n, ovl_n, $time);
        end
        mem[int'(s_addr)] = wlatch;
        ovl_n = 0; set_n = 0;
      end
      s_dq_i = (rd_mode && mem.exists(int'(s_addr))) ? mem[int'(s_addr)] : 8'h5A;
      prev_ovl  = ovl;
      prev_addr = s_addr;
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) ^ (a >> 7) ^ 8'h3C);
  endfunction

  // called at a negedge; returns at the negedge where ready is back
  task automatic do_write(input int a, input logic [7:0] d);
    int k, bad;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 15'(a); wdata = d;
    @(negedge clk);
    req = 1'b0;
    sb[a] = d;
    k = 1; bad = 0;
    while (!ready && k < 50) begin
      if (k <= AS) begin
        if (s_cs_n || !s_we_n || s_oe_n || s_dq_oe) bad++;
      end else if (k <= AS + PUL) begin
        if (s_cs_n || s_we_n || s_oe_n) bad++;
        if (s_dq_oe != (k - AS > GAP)) bad++;
        if (s_dq_oe && s_dq_o != d) bad++;
      end else if (k == AS + PUL + 1) begin
        if (!s_cs_n || !s_we_n || !s_dq_oe || s_dq_o != d) bad++;
      end else begin
        if (!s_cs_n || !s_we_n || s_dq_oe) bad++;
      end
      if (k <= AS + PUL + 1 && s_addr != 15'(a)) bad++;
      @(negedge clk);
      k++;
    end
    check_eq("R4 R5 write strobe shape mismatches", bad, 0);
    check_eq("R2 R10 write latency", k, WR_LAT + 1);
    check_eq("R7 idle strobes", {s_cs_n, s_we_n, s_oe_n, s_dq_oe}, 4'b1110);
  endtask

  task automatic do_read(input int a);
    int k, bad, k_rv;
    logic [7:0] got;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 15'(a);
    @(negedge clk);
    req = 1'b0;
    k = 1; bad = 0; k_rv = 0; got = '0;
    while (!ready && k < 50) begin
      if (k <= RD && (s_cs_n || !s_we_n || s_oe_n || s_dq_oe || s_addr != 15'(a))) bad++;
      if (rvalid) begin
        if (k_rv != 0) bad++;
        k_rv = k; got = rdata;
      end
      @(negedge clk);
      k++;
    end
    check_eq("R3 read strobe mismatches", bad, 0);
    check_eq("R3 read data", int'(got), int'(sb[a]));
    check_eq("R3 rvalid cycle", k_rv, RD + 1);
    check_eq("R2 R10 read latency", k, RD_LAT + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k, bad;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; sleep = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset outputs in reset",
             {ready, s_cs_n, s_we_n, s_oe_n, s_dq_oe, standby, rvalid}, 7'b1111000);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 reset outputs after release",
             {ready, s_cs_n, s_we_n, s_oe_n, s_dq_oe, standby, rvalid}, 7'b1111000);

    // sweep a block of addresses, then read back
    for (int a = 0; a < 512; a++) do_write(a, pat(a));
    for (int a = 0; a < 512; a++) do_read(a);

    // walking address bits and the top address
    for (int b = 0; b < 15; b++) do_write(1 << b, pat(b + 1000));
    do_write(15'h7FFF, 8'hC3);
    for (int b = 0; b < 15; b++) do_read(1 << b);
    do_read(15'h7FFF);

    // back-to-back write then read, same address, extreme data
    do_write(77, 8'h00); do_read(77);
    do_write(77, 8'hFF); do_read(77);

    // R8: standby from idle, request ignored
    sleep = 1'b1;
    @(negedge clk);
    check_eq("R8 standby entry", {standby, ready, s_cs_n}, 3'b101);
    req = 1'b1; we = 1'b1; addr = 15'd9; wdata = ~sb[9];
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!standby || ready || !s_cs_n || s_dq_oe) bad++;
    end
    req = 1'b0;
    check_eq("R8 standby holds, request ignored", bad, 0);
    // R9: wake recovery
    sleep = 1'b0;
    @(negedge clk);
    k = 1; bad = 0;
    while (!ready && k < 50) begin
      if (standby || !s_cs_n) bad++;
      @(negedge clk);
      k++;
    end
    check_eq("R9 wake strobes", bad, 0);
    check_eq("R9 wake recovery length", k, REC + 1);
    do_read(9);
    check_eq("R8 R9 data kept across standby", int'(rdata), int'(sb[9]));

    // R8: sleep raised during a read
    req = 1'b1; we = 1'b0; addr = 15'd300;
    @(negedge clk);
    req = 1'b0; sleep = 1'b1;
    k = 1; bad = 0;
    while (!standby && k < 50) begin
      if (ready) bad++;
      if (rvalid && (k != RD + 1 || rdata != sb[300])) bad++;
      @(negedge clk);
      k++;
    end
    check_eq("R8 ready stays low until standby", bad, 0);
    check_eq("R8 standby after access", k, RD_LAT + 1);
    sleep = 1'b0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    do_read(300);

    repeat (4) @(negedge clk);
    check_eq("R6 bus contention count", viol_bus, 0);
    check_eq("R4 R5 write timing violations", viol_wr, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule